// File: doc/BRIEF.md
# Burst Symbol Tracking Controller

This block decides, sample by sample, whether a spread-spectrum burst receiver is hunting for a preamble or following data symbols. The receiver's correlator supplies a preamble-detect strobe and a per-sample flag that says the data correlation crossed its threshold. From these the controller produces one detect strobe per data symbol. If the expected correlation peak does not arrive, it inserts a synthetic strobe anyway and raises a miss pulse. It also produces bit-clock pulses for the output stage and a level that shows whether tracking is active.

A burst ends in one of three ways: after a programmed number of data symbols, after too many misses, or on an abort request. Each of the first two endings can be switched off. Software or a pin can force a detect or an abort. A punctual mode replaces peak-following with a fixed symbol period, and a continuous-acquisition mode keeps the receiver on preamble symbols only.

Top module: `bst_burst_track`

## Requirements
- R1: While and after synchronous reset, `det_o`, `miss_o`, `bclk_o` and `trk_o` are low and the block is in acquisition (`trk_o`=0).
- R2: All strobes are registered and appear in the cycle after the sample that decides them. An accepted preamble (`pre_det_i` high in acquisition) gives `det_o`=1 and `trk_o`=1 in the next cycle and clears the burst counters. The symbol period is P = `chips_i`+1 samples, and samples inside a symbol are numbered 0..P-1 starting with the sample after the detect.
- R3: In adaptive tracking, `thr_hit_i` on sample P-2 or P-1 produces a detect and restarts the numbering at the next sample. A hit on any earlier sample is ignored.
- R4: If sample P-1 passes without an accepted hit, a detect is still produced, together with `miss_o`=1 in the same cycle, and the miss counter increments.
- R5: The burst length is N = {`blen_hi_i`,`blen_lo_i`} - 2 data symbols. The detect that counts data symbol N returns the block to acquisition (`trk_o` low in that same output cycle). With `len_off_i`=1 tracking continues past N.
- R6: The miss that makes the burst's miss count greater than `miss_lim_i` ends the burst (its detect and miss pulse still appear, with `trk_o` low). With `miss_off_i`=1 misses never end the burst.
- R7: With `punct_i`=1, detects occur only on sample P-1. A hit on that sample produces no miss, hits on earlier samples are ignored, and misses are still counted.
- R8: With `cont_acq_i`=1, an accepted preamble produces `det_o` but the block stays in acquisition and produces no miss pulses.
- R9: With `man_en_i`=1, preamble strobes are ignored. A rising edge of (`mdet_reg_i` OR `mdet_pin_i`) acts on the second clock edge after it. In acquisition it enters tracking like a preamble. In tracking it forces a detect without a miss and restarts the sample numbering.
- R10: A rising edge of (`abort_reg_i` OR `abort_pin_i`) acts on the second clock edge after it. It returns the block to acquisition with no strobe and clears the counters.
- R11: Each tracking detect also gives `bclk_o`. With `qpsk_i`=1 and `mid_off_i`=0, a further `bclk_o` pulse follows sample floor(P/2)-1. With `qpsk_i`=0 or `mid_off_i`=1 there is no mid-symbol pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Baseband sample clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_det_i | input | 1 | Preamble correlation strobe |
| thr_hit_i | input | 1 | Data correlation above threshold on this sample |
| chips_i | input | CHIP_W | Chips per data symbol minus one (1..63) |
| blen_lo_i | input | LEN_W/2 | Burst length field, low byte |
| blen_hi_i | input | LEN_W/2 | Burst length field, high byte |
| miss_lim_i | input | MISS_W | Allowed misses per burst (1..255) |
| qpsk_i | input | 1 | Two bit clocks per symbol |
| punct_i | input | 1 | Fixed-period symbol timing |
| cont_acq_i | input | 1 | Stay in acquisition after preambles |
| man_en_i | input | 1 | Ignore preambles, enable manual detect |
| mid_off_i | input | 1 | Suppress mid-symbol bit clock |
| miss_off_i | input | 1 | Misses never end a burst |
| len_off_i | input | 1 | Symbol count never ends a burst |
| mdet_reg_i | input | 1 | Manual detect request, register bit |
| mdet_pin_i | input | 1 | Manual detect request, pin |
| abort_reg_i | input | 1 | Abort request, register bit |
| abort_pin_i | input | 1 | Abort request, pin |
| det_o | output | 1 | Symbol detect strobe |
| miss_o | output | 1 | Missed detect pulse |
| bclk_o | output | 1 | Bit clock pulse |
| trk_o | output | 1 | High while tracking data symbols |

## Verification
The bench builds the block with its default widths (6-bit chip field, 16-bit burst field, 8-bit miss limit). It programs a 4-sample symbol period, which makes the acceptance window, the mid-symbol pulse and the synthetic peak land on distinct samples within a few cycles. Burst fields of 3 and 5 and a miss limit of 1 bring both burst endings, and their disabling, within about twenty cycles. This includes the smallest legal burst of one data symbol.

// File: rtl/bst_pkg.sv
package bst_pkg;
  typedef enum logic {ST_ACQ = 1'b0, ST_TRK = 1'b1} bst_state_e;

  typedef struct packed {
    logic qpsk;
    logic punct;
    logic cont_acq;
    logic man_en;
    logic mid_off;
    logic miss_off;
    logic len_off;
  } bst_mode_t;
endpackage

// File: rtl/bst_edge_sync.sv
module bst_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic req_a,
  input  logic req_b,
  output logic rise_o
);
  logic r1_q, r2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      r1_q <= 1'b0;
      r2_q <= 1'b0;
    end else begin
      r1_q <= req_a | req_b;
      r2_q <= r1_q;
    end
  end

  // pulse during the cycle before the second edge; acted on at that edge
  assign rise_o = r1_q & ~r2_q;
endmodule

// File: rtl/bst_sym_timer.sv
module bst_sym_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          restart,
  input  logic [CW-1:0] chips,
  output logic          at_end,
  output logic          in_win,
  output logic          at_mid
);
  logic [CW-1:0] cnt_q;
  logic [CW:0]   cnt_p1;
  logic [CW:0]   half;

  always_ff @(posedge clk) begin
    if (rst || !run || restart) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_p1 = {1'b0, cnt_q} + 1'b1;
  assign half   = ({1'b0, chips} + 1'b1) >> 1;
  assign at_end = (cnt_q == chips);
  assign in_win = (cnt_p1 >= {1'b0, chips});
  assign at_mid = (cnt_p1 == half);
endmodule

// File: rtl/bst_burst_cnt.sv
module bst_burst_cnt #(
  parameter int LW = 16,
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc_sym,
  input  logic          inc_miss,
  input  logic [LW-1:0] blen,
  input  logic [MW-1:0] lim,
  output logic          last_sym,
  output logic          over_lim
);
  localparam logic [MW:0] MISS_MAX = '1;

  logic [LW-1:0] sym_q;
  logic [MW:0]   miss_q;
  logic [LW:0]   sym_p1, n_sym;
  logic [MW+1:0] miss_p1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sym_q  <= '0;
      miss_q <= '0;
    end else begin
      if (inc_sym) sym_q <= sym_q + 1'b1;
      if (inc_miss && miss_q != MISS_MAX) miss_q <= miss_q + 1'b1;
    end
  end

  assign sym_p1   = {1'b0, sym_q} + 1'b1;
  assign n_sym    = {1'b0, blen} - 2'd2;
  assign miss_p1  = {1'b0, miss_q} + 1'b1;
  assign last_sym = (sym_p1 == n_sym);
  assign over_lim = (miss_p1 > {2'b00, lim});
endmodule

// File: rtl/bst_burst_track.sv
module bst_burst_track #(
  parameter int CHIP_W = 6,
  parameter int LEN_W  = 16,
  parameter int MISS_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pre_det_i,
  input  logic                 thr_hit_i,
  input  logic [CHIP_W-1:0]    chips_i,
  input  logic [LEN_W/2-1:0]   blen_lo_i,
  input  logic [LEN_W/2-1:0]   blen_hi_i,
  input  logic [MISS_W-1:0]    miss_lim_i,
  input  logic                 qpsk_i,
  input  logic                 punct_i,
  input  logic                 cont_acq_i,
  input  logic                 man_en_i,
  input  logic                 mid_off_i,
  input  logic                 miss_off_i,
  input  logic                 len_off_i,
  input  logic                 mdet_reg_i,
  input  logic                 mdet_pin_i,
  input  logic                 abort_reg_i,
  input  logic                 abort_pin_i,
  output logic                 det_o,
  output logic                 miss_o,
  output logic                 bclk_o,
  output logic                 trk_o
);
  import bst_pkg::*;

  logic [CHIP_W-1:0] chips_q;
  logic [LEN_W-1:0]  blen_q;
  logic [MISS_W-1:0] lim_q;
  bst_mode_t         mode_q;
  bst_state_e        state_q, state_n;

  logic md_rise, ab_rise;
  logic at_end, in_win, at_mid;
  logic last_sym, over_lim;
  logic det_n, miss_n, bclk_n;
  logic clr, inc_sym, inc_miss, restart;

  // register fields captured on the sample clock
  always_ff @(posedge clk) begin
    if (rst) begin
      chips_q <= '0;
      blen_q  <= '0;
      lim_q   <= '0;
      mode_q  <= '0;
    end else begin
      chips_q <= chips_i;
      blen_q  <= {blen_hi_i, blen_lo_i};
      lim_q   <= miss_lim_i;
      mode_q  <= '{qpsk: qpsk_i, punct: punct_i, cont_acq: cont_acq_i,
                   man_en: man_en_i, mid_off: mid_off_i,
                   miss_off: miss_off_i, len_off: len_off_i};
    end
  end

  bst_edge_sync u_mdet (.clk(clk), .rst(rst), .req_a(mdet_reg_i),
                        .req_b(mdet_pin_i), .rise_o(md_rise));
  bst_edge_sync u_abort (.clk(clk), .rst(rst), .req_a(abort_reg_i),
                         .req_b(abort_pin_i), .rise_o(ab_rise));

  bst_sym_timer #(.CW(CHIP_W)) u_timer (
    .clk(clk), .rst(rst), .run(state_q == ST_TRK), .restart(restart),
    .chips(chips_q), .at_end(at_end), .in_win(in_win), .at_mid(at_mid));

  bst_burst_cnt #(.LW(LEN_W), .MW(MISS_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(clr), .inc_sym(inc_sym), .inc_miss(inc_miss),
    .blen(blen_q), .lim(lim_q), .last_sym(last_sym), .over_lim(over_lim));

  always_comb begin
    state_n  = state_q;
    det_n    = 1'b0;
    miss_n   = 1'b0;
    bclk_n   = 1'b0;
    clr      = 1'b0;
    inc_sym  = 1'b0;
    inc_miss = 1'b0;
    restart  = 1'b0;
    if (ab_rise) begin
      state_n = ST_ACQ;
      clr     = 1'b1;
      restart = 1'b1;
    end else if (state_q == ST_ACQ) begin
      if ((md_rise && mode_q.man_en) || (pre_det_i && !mode_q.man_en)) begin
        det_n = 1'b1;
        clr   = 1'b1;
        if (!mode_q.cont_acq) state_n = ST_TRK;
      end
    end else begin
      if (md_rise && mode_q.man_en) begin
        det_n = 1'b1;
      end else if (mode_q.punct) begin
        if (at_end) begin
          det_n  = 1'b1;
          miss_n = !thr_hit_i;
        end
      end else if (in_win && thr_hit_i) begin
        det_n = 1'b1;
      end else if (at_end) begin
        det_n  = 1'b1;
        miss_n = 1'b1;
      end
      if (det_n) begin
        bclk_n  = 1'b1;
        restart = 1'b1;
        inc_sym = 1'b1;
        if (!mode_q.len_off && last_sym) state_n = ST_ACQ;
      end
      if (miss_n) begin
        inc_miss = 1'b1;
        if (!mode_q.miss_off && over_lim) state_n = ST_ACQ;
      end
      if (at_mid && mode_q.qpsk && !mode_q.mid_off) bclk_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_ACQ;
      det_o   <= 1'b0;
      miss_o  <= 1'b0;
      bclk_o  <= 1'b0;
    end else begin
      state_q <= state_n;
      det_o   <= det_n;
      miss_o  <= miss_n;
      bclk_o  <= bclk_n;
    end
  end

  assign trk_o = (state_q == ST_TRK);
endmodule

// File: rtl/bst_burst_track_chk.sv
module bst_burst_track_chk (
  input logic clk,
  input logic rst,
  input logic trk,
  input logic det,
  input logic miss,
  input logic bclk,
  input logic ab_rise,
  input logic qpsk,
  input logic mid_off
);
  // R4: a miss pulse never comes without its inserted detect
  p_miss_has_det_r4: assert property (@(posedge clk) disable iff (rst)
    miss |-> det);

  // R8: misses arise only from a sample taken while tracking
  p_miss_from_trk_r8: assert property (@(posedge clk) disable iff (rst)
    miss |-> $past(trk));

  // R11: bit clocks only come from tracking samples
  p_bclk_from_trk_r11: assert property (@(posedge clk) disable iff (rst)
    bclk |-> $past(trk));

  // R11: a bit clock without detect needs QPSK and the mid pulse enabled
  p_mid_gate_r11: assert property (@(posedge clk) disable iff (rst)
    (bclk && !det) |-> ($past(qpsk, 2) && !$past(mid_off, 2)));

  // R10: an abort leaves acquisition with no strobe
  p_abort_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    ab_rise |=> (!trk && !det && !bclk && !miss));

  // R2: entering tracking always comes with a detect strobe
  p_entry_det_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(trk) |-> det);
endmodule

bind bst_burst_track bst_burst_track_chk i_chk (
  .clk(clk), .rst(rst), .trk(trk_o), .det(det_o), .miss(miss_o),
  .bclk(bclk_o), .ab_rise(ab_rise), .qpsk(qpsk_i), .mid_off(mid_off_i));

// File: tb/test_bst_burst_track.sv
module test_bst_burst_track;
  localparam int CLK_P = 10;
  localparam int NVEC  = 23;
  // row bits: {pre, hit, det, miss, bclk, trk}; chips=3, burst field 5, limit 1, QPSK
  localparam logic [5:0] VEC [0:NVEC-1] = '{
    6'b10_1001, 6'b00_0001, 6'b00_0011, 6'b01_1011, 6'b00_0001,
    6'b00_0011, 6'b00_0001, 6'b00_1111, 6'b01_0001, 6'b00_0011,
    6'b00_0001, 6'b01_1010, 6'b00_0000, 6'b10_1001, 6'b00_0001,
    6'b00_0011, 6'b00_0001, 6'b00_1111, 6'b00_0001, 6'b00_0011,
    6'b00_0001, 6'b00_1110, 6'b00_0000};

  logic clk = 0, rst = 1;
  logic pre_det = 0, thr_hit = 0;
  logic [5:0] chips = 6'd3;
  logic [7:0] blen_lo = 8'd5, blen_hi = 8'd0, lim = 8'd1;
  logic qpsk = 1, punct = 0, cont_acq = 0, man_en = 0, mid_off = 0;
  logic miss_off = 0, len_off = 0;
  logic mdet_reg = 0, mdet_pin = 0, abort_reg = 0, abort_pin = 0;
  logic det, miss, bclk, trk;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  bst_burst_track i_bst_burst_track (
    .clk(clk), .rst(rst), .pre_det_i(pre_det), .thr_hit_i(thr_hit),
    .chips_i(chips), .blen_lo_i(blen_lo), .blen_hi_i(blen_hi),
    .miss_lim_i(lim), .qpsk_i(qpsk), .punct_i(punct), .cont_acq_i(cont_acq),
    .man_en_i(man_en), .mid_off_i(mid_off), .miss_off_i(miss_off),
    .len_off_i(len_off), .mdet_reg_i(mdet_reg), .mdet_pin_i(mdet_pin),
    .abort_reg_i(abort_reg), .abort_pin_i(abort_pin),
    .det_o(det), .miss_o(miss), .bclk_o(bclk), .trk_o(trk));

  task automatic cyc(input logic p, input logic h);
    pre_det = p;
    thr_hit = h;
    @(posedge clk);
    @(negedge clk);
    pre_det = 0;
    thr_hit = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0);
  endtask

  task automatic chk(input string req, input logic [3:0] exp);
    checks++;
    if ({det, miss, bclk, trk} !== exp) begin
      errors++;
      $display("FAIL %s: {det,miss,bclk,trk} got %b expected %b", req,
               {det, miss, bclk, trk}, exp);
    end
  endtask

  task automatic do_abort();
    abort_reg = 1;
    cyc(0, 0);
    chk("R10 abort not yet active", {det, miss, bclk, 1'b1});
    cyc(0, 0);
    chk("R10 abort back to acquisition", 4'b0000);
    abort_reg = 0;
    idle(2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    idle(3);
    chk("R1 during reset", 4'b0000);
    rst = 0;
    idle(2);
    chk("R1 after reset", 4'b0000);

    // main table: R2 R3 R4 R5 R6 R11
    for (int i = 0; i < NVEC; i++) begin
      cyc(VEC[i][5], VEC[i][4]);
      chk($sformatf("table row %0d (R3 R4 R5 R6 R11)", i), VEC[i][3:0]);
    end

    // R7 punctual timing
    punct = 1; lim = 8'd10; blen_lo = 8'd100;
    idle(2);
    cyc(1, 0); chk("R2 entry", 4'b1001);
    cyc(0, 0); cyc(0, 0);
    cyc(0, 1); chk("R7 early hit ignored", 4'b0001);
    cyc(0, 1); chk("R7 hit at last sample no miss", 4'b1011);
    idle(3);
    cyc(0, 0); chk("R7 fixed period miss", 4'b1111);
    do_abort();
    punct = 0;

    // R8 continuous acquisition
    cont_acq = 1;
    idle(2);
    cyc(1, 0); chk("R8 preamble strobe stays in acquisition", 4'b1000);
    cyc(0, 0); chk("R8 quiet after", 4'b0000);
    cont_acq = 0;

    // R9 manual detect
    man_en = 1;
    idle(2);
    cyc(1, 0); chk("R9 preamble ignored", 4'b0000);
    mdet_pin = 1;
    cyc(0, 0); chk("R9 first edge no effect", 4'b0000);
    cyc(0, 0); chk("R9 manual entry at second edge", 4'b1001);
    mdet_pin = 0;
    cyc(0, 0);
    mdet_pin = 1;
    cyc(0, 0);
    cyc(0, 0); chk("R9 forced detect in tracking", 4'b1011);
    mdet_pin = 0;
    idle(2);
    cyc(0, 0); chk("R9 no detect at old peak", 4'b0001);
    cyc(0, 0); chk("R9 realigned inserted detect", 4'b1111);
    do_abort();
    man_en = 0;

    // R11 mid pulse suppressed, then BPSK
    mid_off = 1;
    idle(2);
    cyc(1, 0); cyc(0, 0);
    cyc(0, 0); chk("R11 mid pulse suppressed", 4'b0001);
    cyc(0, 0);
    cyc(0, 0); chk("R11 end pulse kept", 4'b1111);
    do_abort();
    mid_off = 0; qpsk = 0;
    idle(2);
    cyc(1, 0); cyc(0, 0);
    cyc(0, 0); chk("R11 BPSK no mid pulse", 4'b0001);
    cyc(0, 0);
    cyc(0, 0); chk("R11 BPSK end pulse", 4'b1111);
    do_abort();
    qpsk = 1;

    // R5 shortest burst and disabled length check
    blen_lo = 8'd3;
    idle(2);
    cyc(1, 0); cyc(0, 0); cyc(0, 0);
    cyc(0, 1); chk("R5 one-symbol burst ends", 4'b1010);
    len_off = 1;
    idle(2);
    cyc(1, 0); cyc(0, 0); cyc(0, 0);
    cyc(0, 1); chk("R5 length check off", 4'b1011);
    do_abort();
    len_off = 0;

    // R6 miss termination disabled
    blen_lo = 8'd100; lim = 8'd1; miss_off = 1;
    idle(2);
    cyc(1, 0);
    for (int s = 0; s < 3; s++) begin
      idle(3);
      cyc(0, 0); chk("R6 miss check off keeps tracking", 4'b1111);
    end
    do_abort();
    miss_off = 0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule